// File: doc/BRIEF.md
# Reselection Responder for an Initiator on a Parallel Peripheral Bus

This block sits on the initiator side of a parallel, wired-OR peripheral bus. It samples the select, input/output direction and busy lines, the 8-bit data bus and its parity bit. From these it decides whether a target is reconnecting to this initiator. A reconnecting target raises select and I/O, releases busy, and places on the data bus its own ID bit together with the initiator's ID bit. The responder waits until that picture has held steady for a settle time. It then qualifies the data byte, reports which target is calling back, and answers by driving busy.

A reconnection is accepted only if the byte carries odd parity and has exactly two bits set. Otherwise the responder stays silent and leaves busy released. Once it has answered, the responder keeps busy driven until the target drops select, and then lets go. All delays are counted in clock cycles and set by parameters. What the target does after the hand-back is handled elsewhere.

Top module: `resel_responder`

## Requirements
- R1: The responder qualifies a reconnection only when select and I/O are high, busy is low and the data bit indexed by `own_id_i` is high, on SETTLE_CYC consecutive rising edges. A single edge without this condition restarts the count from zero.
- R2: Parity is odd. The eight data bits and `dbp_i` must together hold an odd number of ones. If they do not, the attempt is ignored: no strobe is issued and `bsy_drv_o` stays low.
- R3: The data bus must hold exactly two set bits. With one, three or more set bits, the attempt is ignored: no strobe is issued and `bsy_drv_o` stays low.
- R4: On the edge that completes an accepted qualification, `resel_stb_o` goes high for exactly one cycle. On the same edge, `targ_id_o` is loaded with the 3-bit binary index of the set data bit that is not bit `own_id_i`. `targ_id_o` keeps that value until the next accepted reconnection.
- R5: `bsy_drv_o` rises exactly RESP_DLY cycles after the strobe edge. RESP_DLY must be at least 1 and no larger than ABORT_CYC, so the answer always falls within the abort window.
- R6: While `bsy_drv_o` is high, the first edge that samples `sel_i` low drops `bsy_drv_o` on that same edge.
- R7: After a synchronous reset, `bsy_drv_o`, `resel_stb_o` and `targ_id_o` are all zero.
- R8: Each unbroken stretch of the condition in R1 is judged only once. If an attempt is rejected, a later repair of the data while the condition still holds brings no response. Only after the condition breaks and then settles again can the attempt be accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Sampled select line |
| io_i | input | 1 | Sampled I/O direction line |
| bsy_i | input | 1 | Sampled busy line |
| db_i | input | 8 | Sampled data bus |
| dbp_i | input | 1 | Sampled data bus parity bit |
| own_id_i | input | 3 | This initiator's ID |
| bsy_drv_o | output | 1 | Busy drive enable |
| resel_stb_o | output | 1 | One-cycle reconnection-accepted pulse |
| targ_id_o | output | 3 | Binary ID of the reconnecting target |

## Verification
The bench builds the responder with SETTLE_CYC=4, RESP_DLY=2 and ABORT_CYC=6. With a four-cycle settle, the strobe edge can be pinned exactly, and a condition that breaks one cycle short can be shown to restart the count. With a two-cycle answer delay, the bench can prove that busy is still low on the edge before it is due. These small values let every accepted and rejected pattern, as well as the repair-without-break case, complete in a few dozen cycles.

// File: rtl/resel_pkg.sv
package resel_pkg;

    localparam int unsigned DB_W = 8;
    localparam int unsigned ID_W = $clog2(DB_W);

    typedef logic [DB_W-1:0] db_t;
    typedef logic [ID_W-1:0] id_t;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_HOLD = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic sel;
        logic io;
        logic bsy;
        db_t  db;
        logic par;
    } bus_s;

    typedef struct packed {
        logic ok;
        id_t  targ;
    } verdict_s;

    function automatic logic odd_parity_ok(input db_t d, input logic p);
        return (^{d, p}) == 1'b1;
    endfunction

    function automatic int unsigned ones_in(input db_t d);
        int unsigned n;
        n = 0;
        for (int i = 0; i < DB_W; i++) n += int'(d[i]);
        return n;
    endfunction

    function automatic id_t lowest_set(input db_t d);
        id_t r;
        r = '0;
        for (int i = DB_W - 1; i >= 0; i--)
            if (d[i]) r = id_t'(i);
        return r;
    endfunction

endpackage

// File: rtl/resel_check.sv
module resel_check
    import resel_pkg::*;
(
    input  bus_s     bus,
    input  id_t      own,
    output verdict_s verdict
);
    db_t own_mask;
    db_t other;

    always_comb begin
        own_mask     = db_t'(1) << own;
        other        = bus.db & ~own_mask;
        verdict.ok   = odd_parity_ok(bus.db, bus.par)
                     && (ones_in(bus.db) == 2)
                     && ((bus.db & own_mask) != '0);
        verdict.targ = lowest_set(other);
    end
endmodule

// File: rtl/resel_qualify.sv
module resel_qualify
    import resel_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  bus_s bus,
    input  id_t  own,
    input  logic armed,
    output logic settled
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(SETTLE_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    logic             cond;
    logic [CNT_W-1:0] cnt;

    assign cond    = bus.sel && bus.io && !bus.bsy && bus.db[own];
    assign settled = armed && cond && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || !(armed && cond))
            cnt <= '0;
        else if (cnt != CNT_TOP)
            cnt <= cnt + 1'b1;
    end

    // R1: a settle event needs the condition on the previous edge too (when the count is above one)
    a_r1_steady_hold: assert property (@(posedge clk) disable iff (rst)
        (settled && SETTLE_CYC > 1) |-> $past(cond));

    // R8: the count never passes its saturation value
    a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_TOP);
endmodule

// File: rtl/resel_handshake.sv
module resel_handshake
    import resel_pkg::*;
#(
    parameter int unsigned RESP_DLY  = 2,
    parameter int unsigned ABORT_CYC = 25
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     settled,
    input  verdict_s verdict,
    input  logic     sel,
    output logic     armed,
    output logic     bsy_drv,
    output logic     stb,
    output id_t      targ_id
);
    localparam int unsigned DW = $clog2(RESP_DLY + 1);
    localparam logic [DW-1:0] D_LAST = DW'(RESP_DLY - 1);
    localparam int unsigned AW = $clog2(ABORT_CYC + 2);

    hs_state_e        state;
    logic [DW-1:0]    dcnt;
    logic [AW-1:0]    since_stb;

    assign armed   = (state == HS_IDLE);
    assign bsy_drv = (state == HS_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= HS_IDLE;
            dcnt    <= '0;
            stb     <= 1'b0;
            targ_id <= '0;
        end else begin
            stb <= 1'b0;
            unique case (state)
                HS_IDLE: begin
                    dcnt <= '0;
                    if (settled && verdict.ok) begin
                        state   <= HS_WAIT;
                        stb     <= 1'b1;
                        targ_id <= verdict.targ;
                    end
                end
                HS_WAIT: begin
                    if (dcnt == D_LAST) state <= HS_HOLD;
                    else                dcnt  <= dcnt + 1'b1;
                end
                HS_HOLD: begin
                    if (!sel) state <= HS_IDLE;
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

    // watch counter for the abort window
    always_ff @(posedge clk) begin
        if (rst || stb)
            since_stb <= '0;
        else if (state == HS_WAIT && since_stb != AW'(ABORT_CYC + 1))
            since_stb <= since_stb + 1'b1;
    end

    // R5: busy is driven before the abort window closes
    a_r5_abort_window: assert property (@(posedge clk) disable iff (rst)
        (state == HS_WAIT) |-> (since_stb < AW'(ABORT_CYC)));

    // R4: the strobe is a single-cycle pulse
    a_r4_one_pulse: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);

    // R6: select low while holding busy drops busy on the next edge
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        (bsy_drv && !sel) |=> !bsy_drv);
endmodule

// File: rtl/resel_responder.sv
module resel_responder
    import resel_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 50,
    parameter int unsigned RESP_DLY   = 2,
    parameter int unsigned ABORT_CYC  = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_i,
    input  logic       io_i,
    input  logic       bsy_i,
    input  logic [7:0] db_i,
    input  logic       dbp_i,
    input  logic [2:0] own_id_i,
    output logic       bsy_drv_o,
    output logic       resel_stb_o,
    output logic [2:0] targ_id_o
);
    bus_s     bus;
    verdict_s verdict;
    logic     armed;
    logic     settled;

    assign bus = '{sel: sel_i, io: io_i, bsy: bsy_i, db: db_i, par: dbp_i};

    resel_check u_check (
        .bus     (bus),
        .own     (own_id_i),
        .verdict (verdict)
    );

    resel_qualify #(.SETTLE_CYC(SETTLE_CYC)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus),
        .own     (own_id_i),
        .armed   (armed),
        .settled (settled)
    );

    resel_handshake #(.RESP_DLY(RESP_DLY), .ABORT_CYC(ABORT_CYC)) u_hs (
        .clk     (clk),
        .rst     (rst),
        .settled (settled),
        .verdict (verdict),
        .sel     (sel_i),
        .armed   (armed),
        .bsy_drv (bsy_drv_o),
        .stb     (resel_stb_o),
        .targ_id (targ_id_o)
    );

    // R2: an accepted byte carried odd parity
    a_r2_parity: assert property (@(posedge clk) disable iff (rst)
        resel_stb_o |-> $past(^{db_i, dbp_i}));

    // R3: an accepted byte had exactly two set bits
    a_r3_two_bits: assert property (@(posedge clk) disable iff (rst)
        resel_stb_o |-> $past($countones(db_i) == 2));

    // R1: acceptance needed select, I/O and released busy on the deciding edge
    a_r1_condition: assert property (@(posedge clk) disable iff (rst)
        resel_stb_o |-> $past(sel_i && io_i && !bsy_i));
endmodule

// File: tb/resel_responder_test.sv
module resel_responder_test;
    localparam int S = 4;
    localparam int D = 2;
    localparam int A = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_i = 1'b0, io_i = 1'b0, bsy_i = 1'b0, dbp_i = 1'b0;
    logic [7:0] db_i = '0;
    logic [2:0] own_id_i = '0;
    logic       bsy_drv_o, resel_stb_o;
    logic [2:0] targ_id_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    resel_responder #(.SETTLE_CYC(S), .RESP_DLY(D), .ABORT_CYC(A)) uut (
        .clk(clk), .rst(rst), .sel_i(sel_i), .io_i(io_i), .bsy_i(bsy_i),
        .db_i(db_i), .dbp_i(dbp_i), .own_id_i(own_id_i),
        .bsy_drv_o(bsy_drv_o), .resel_stb_o(resel_stb_o), .targ_id_o(targ_id_o)
    );

    typedef struct packed {
        logic [7:0] db;
        logic       bad;
        logic [2:0] own;
        logic       ok;
        logic [2:0] id;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{db: 8'h81, bad: 1'b0, own: 3'd0, ok: 1'b1, id: 3'd7},
        '{db: 8'h0C, bad: 1'b0, own: 3'd3, ok: 1'b1, id: 3'd2},
        '{db: 8'h60, bad: 1'b0, own: 3'd5, ok: 1'b1, id: 3'd6},
        '{db: 8'h14, bad: 1'b1, own: 3'd2, ok: 1'b0, id: 3'd0},
        '{db: 8'h04, bad: 1'b0, own: 3'd2, ok: 1'b0, id: 3'd0},
        '{db: 8'h16, bad: 1'b0, own: 3'd2, ok: 1'b0, id: 3'd0},
        '{db: 8'hFF, bad: 1'b0, own: 3'd7, ok: 1'b0, id: 3'd0},
        '{db: 8'h41, bad: 1'b0, own: 3'd6, ok: 1'b1, id: 3'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic good_par(input logic [7:0] d);
        return ~^d;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic s, input logic i, input logic [7:0] d, input logic p);
        sel_i = s; io_i = i; bsy_i = 1'b0; db_i = d; dbp_i = p;
    endtask

    task automatic idle_bus();
        drive(1'b0, 1'b0, 8'h00, 1'b0);
        repeat (2) step();
    endtask

    task automatic target_release(input string req);
        bsy_i = 1'b1;
        repeat (3) step();
        chk({req, " busy held while select high"}, bsy_drv_o, 1);
        sel_i = 1'b0;
        step();
        chk({req, " busy released after select low"}, bsy_drv_o, 0);
        idle_bus();
    endtask

    task automatic attempt(input vec_t v, input string req);
        int early;
        early = 0;
        own_id_i = v.own;
        drive(1'b1, 1'b1, v.db, good_par(v.db) ^ v.bad);
        for (int k = 0; k < S - 1; k++) begin
            step();
            early |= int'(resel_stb_o) | int'(bsy_drv_o);
        end
        chk({req, " nothing before settle"}, early, 0);
        step();
        chk({req, " strobe on settle edge"}, resel_stb_o, int'(v.ok));
        if (v.ok) chk("R4 target id", targ_id_o, v.id);
        for (int k = 0; k < D - 1; k++) begin
            step();
            chk("R5 busy not early", bsy_drv_o, 0);
        end
        step();
        chk({req, " busy after delay"}, bsy_drv_o, int'(v.ok));
        if (v.ok) begin
            target_release("R6");
        end else begin
            early = 0;
            for (int k = 0; k < 6; k++) begin
                step();
                early |= int'(bsy_drv_o) | int'(resel_stb_o);
            end
            chk({req, " rejected stays silent"}, early, 0);
            idle_bus();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int seen;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R7 reset busy", bsy_drv_o, 0);
        chk("R7 reset strobe", resel_stb_o, 0);
        chk("R7 reset id", targ_id_o, 0);

        // table walk
        foreach (VECS[n]) begin
            string tag;
            if (VECS[n].ok)       tag = "R4";
            else if (VECS[n].bad) tag = "R2";
            else                  tag = "R3";
            attempt(VECS[n], tag);
        end

        // R1: a break one edge short restarts the count
        own_id_i = 3'd1;
        drive(1'b1, 1'b1, 8'h22, good_par(8'h22));
        seen = 0;
        for (int k = 0; k < S - 1; k++) begin step(); seen |= int'(resel_stb_o); end
        sel_i = 1'b0;
        step();
        sel_i = 1'b1;
        for (int k = 0; k < S - 1; k++) begin step(); seen |= int'(resel_stb_o); end
        chk("R1 restart after break", seen, 0);
        step();
        chk("R1 strobe after full settle", resel_stb_o, 1);
        chk("R4 id after restart", targ_id_o, 5);
        repeat (D) step();
        chk("R5 busy on time", bsy_drv_o, 1);
        target_release("R6");

        // R1: own bit absent
        own_id_i = 3'd4;
        drive(1'b1, 1'b1, 8'h03, good_par(8'h03));
        seen = 0;
        for (int k = 0; k < S + D + 3; k++) begin step(); seen |= int'(bsy_drv_o) | int'(resel_stb_o); end
        chk("R1 own bit missing ignored", seen, 0);
        chk("R4 id kept", targ_id_o, 5);
        idle_bus();

        // R1: I/O low
        own_id_i = 3'd0;
        drive(1'b1, 1'b0, 8'h81, good_par(8'h81));
        seen = 0;
        for (int k = 0; k < S + D + 3; k++) begin step(); seen |= int'(bsy_drv_o) | int'(resel_stb_o); end
        chk("R1 io low ignored", seen, 0);
        idle_bus();

        // R8: repair without a break brings no response
        own_id_i = 3'd2;
        drive(1'b1, 1'b1, 8'h0C, ~good_par(8'h0C));
        seen = 0;
        for (int k = 0; k < S + 1; k++) begin step(); seen |= int'(resel_stb_o); end
        dbp_i = good_par(8'h0C);
        for (int k = 0; k < S + D + 2; k++) begin step(); seen |= int'(bsy_drv_o) | int'(resel_stb_o); end
        chk("R8 no retry without break", seen, 0);
        sel_i = 1'b0;
        step();
        sel_i = 1'b1;
        repeat (S) step();
        chk("R8 accepted after break", resel_stb_o, 1);
        chk("R4 id after retry", targ_id_o, 3);
        repeat (D) step();
        chk("R5 busy after retry", bsy_drv_o, 1);
        target_release("R6");

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule